// File: doc/BRIEF.md
# Event counter performance monitor

This block counts hardware events for a processor core. It has one free-running cycle counter and a parameterised number of 32-bit event counters. Each event counter is bound to one line of an incoming event vector, and that vector carries one-cycle pulses. Each counter is also filtered by the privilege level that comes with the pulses. Software drives the block through a simple word-addressed register bus. Writes commit on the rising clock edge and reads are combinational.

Each counter has an enable bit and an interrupt-enable bit, kept in bitmask registers. Every mask has a set view and a clear view. When a counter wraps, it raises a sticky overflow flag, and software clears that flag by writing a one to it. All counters share a single interrupt line. The event counters sit behind a select register, so one type port and one data port serve any number of counters. The cycle counter has its own data port. It can also advance once every 64 cycles, and it can be stopped while the core is in a debug-inhibit state.

Top module: `perfmon_unit`

## Requirements
- R1: After reset, the counter-enable mask, the interrupt-enable mask, the overflow flags, the select register, the cycle counter and all control bits are zero, and `irq` is low.
- R2: Control register at address 0. Bit 0 is the global run bit, bit 3 selects divide-by-64, bit 4 drives `export_en` and bit 5 stops cycle counting while `dbg_inhibit` is high. Writing bit 1 zeroes every event counter and writing bit 2 zeroes the cycle counter and its prescaler. Both of those bits act only for that cycle and read as zero. Bits 15:11 read the number of event counters, and every other bit reads zero.
- R3: In all bitmask registers, event counter k is bit k and the cycle counter is bit 31. The enable mask is written through address 1 (ones set bits) and address 2 (ones clear bits), and the interrupt-enable mask through addresses 3 and 4 in the same way. Both addresses of a pair read the mask, and bits of unimplemented counters stay zero.
- R4: An event counter advances by one on a clock edge only when the global run bit is set, its own enable bit is set, and its selected event is present at an allowed privilege level.
- R5: Privilege filter bits in a type register: bit 30 excludes level 0, bit 31 excludes level 1, bit 27 admits level 2 (otherwise excluded), and level 3 is always admitted.
- R6: The type register (address 7) keeps only the bits under mask 0xC80003FF. Bits 9:0 name the event. Event 0x11 counts every clock cycle. Any other event number equal to or above the event-vector width never counts.
- R7: The select register (address 6) keeps bits 4:0. Type and data (address 8) reach event counter `sel`. An unimplemented selection reads zero and ignores writes, except selection 31, where the type port reaches the cycle counter's filter and only bits 31, 30 and 27 are writable.
- R8: A counter that advances from all-ones to zero sets its overflow flag (address 5). Writing a one to a flag clears it, zero bits have no effect, and a direct software write never sets a flag. A wrap in the same cycle as a clearing write leaves the flag set.
- R9: `irq` is high exactly when some overflow flag and its interrupt-enable bit are both set.
- R10: The cycle counter (address 9) is directly writable. It advances when the global run bit and enable bit 31 are set and its filter admits the current level. In divide-by-64 mode it advances once every 64 such cycles, counted from the last prescaler reset.
- R11: When control bit 5 and `dbg_inhibit` are both high, the cycle counter and its prescaler hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ev_pulse | input | NUM_EVENTS | One-cycle event pulses, indexed by event number |
| priv_lvl | input | 2 | Privilege level of the current cycle |
| dbg_inhibit | input | 1 | Core is in the debug-inhibit state |
| export_en | output | 1 | Event export enable from the control register |
| irq | output | 1 | Shared overflow interrupt |

## Verification
The bench sweeps every event number (including ones beyond the event vector) across all counters with pseudo-random pulse vectors. A counter wired to the wrong vector line, or one that aliased out-of-range numbers, would miss the arithmetic totals. It tries all eight filter combinations at all four privilege levels, which catches an inverted or swapped filter bit. It also aims at the wrap boundary: a flag must appear on a real wrap and not on a software write of all-ones, and a wrap in the same cycle as a clearing write must survive, which a clear-wins design would lose. Divide-by-64 windows of 127 and 130 cycles, the debug stop, and writes through unimplemented selections all have to land exactly, so an off-by-one prescaler or a leaky select decode would show.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int SEL_W   = 5;
    localparam int CYC_BIT = 31;
    localparam int PRE_W   = 6;
    localparam int EVNUM_W = 10;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_ENSET = 4'd1;
    localparam logic [ADDR_W-1:0] A_ENCLR = 4'd2;
    localparam logic [ADDR_W-1:0] A_IESET = 4'd3;
    localparam logic [ADDR_W-1:0] A_IECLR = 4'd4;
    localparam logic [ADDR_W-1:0] A_OVF   = 4'd5;
    localparam logic [ADDR_W-1:0] A_SEL   = 4'd6;
    localparam logic [ADDR_W-1:0] A_TYPE  = 4'd7;
    localparam logic [ADDR_W-1:0] A_DATA  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CYC   = 4'd9;

    localparam logic [DATA_W-1:0] TYPE_WMASK = 32'hC800_03FF;
    localparam logic [DATA_W-1:0] FILT_WMASK = 32'hC800_0000;
    localparam logic [EVNUM_W-1:0] EV_CYCLES = 10'h011;

    localparam int B_EXCL_L1 = 31;
    localparam int B_EXCL_L0 = 30;
    localparam int B_INCL_L2 = 27;

    localparam int C_EN   = 0;
    localparam int C_PRST = 1;
    localparam int C_CRST = 2;
    localparam int C_DIV  = 3;
    localparam int C_EXP  = 4;
    localparam int C_DBG  = 5;
    localparam int C_NLO  = 11;

    typedef struct packed {
        logic dbg_stop;
        logic export_on;
        logic div64;
        logic run;
    } ctrl_t;

    // Privilege filter: decides whether a counter may advance at this level.
    function automatic logic level_allowed(input logic [DATA_W-1:0] typ,
                                           input logic [1:0] lvl);
        case (lvl)
            2'd0:    return !typ[B_EXCL_L0];
            2'd1:    return !typ[B_EXCL_L1];
            2'd2:    return typ[B_INCL_L2];
            default: return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/perfmon_evcnt.sv
module perfmon_evcnt
    import perfmon_pkg::*;
#(
    parameter int NUM_EVENTS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active,
    input  logic                  zero_all,
    input  logic                  wr_type,
    input  logic                  wr_cnt,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_EVENTS-1:0] ev_pulse,
    input  logic [1:0]            lvl,
    output logic [DATA_W-1:0]     cnt_o,
    output logic [DATA_W-1:0]     type_o,
    output logic                  wrap_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] typ;
    } ev_state_t;

    ev_state_t st_d, st_q;
    logic [EVNUM_W-1:0] ev_num;
    logic hit;
    logic bump;

    always_comb begin
        ev_num = st_q.typ[EVNUM_W-1:0];
        hit = 1'b0;
        for (int i = 0; i < NUM_EVENTS; i++) begin
            if (ev_num == EVNUM_W'(i)) hit = ev_pulse[i];
        end
        if (ev_num == EV_CYCLES) hit = 1'b1;
        bump = active && hit && level_allowed(st_q.typ, lvl);

        st_d   = st_q;
        wrap_o = 1'b0;
        if (zero_all) begin
            st_d.cnt = '0;
        end else if (wr_cnt) begin
            st_d.cnt = wdata;
        end else if (bump) begin
            st_d.cnt = st_q.cnt + DATA_W'(1);
            wrap_o   = &st_q.cnt;
        end
        if (wr_type) st_d.typ = wdata & TYPE_WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign type_o = st_q.typ;
endmodule

// File: rtl/perfmon_cyccnt.sv
module perfmon_cyccnt
    import perfmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              div64,
    input  logic              zero_all,
    input  logic              wr_cnt,
    input  logic              wr_filt,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        lvl,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] filt_o,
    output logic              wrap_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] filt;
        logic [PRE_W-1:0]  pre;
    } cyc_state_t;

    cyc_state_t st_d, st_q;
    logic run;
    logic adv;

    always_comb begin
        run  = active && level_allowed(st_q.filt, lvl);
        adv  = run && (!div64 || (&st_q.pre));
        st_d   = st_q;
        wrap_o = 1'b0;
        if (zero_all) begin
            st_d.pre = '0;
        end else if (run && div64) begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end
        if (zero_all) begin
            st_d.cnt = '0;
        end else if (wr_cnt) begin
            st_d.cnt = wdata;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + DATA_W'(1);
            wrap_o   = &st_q.cnt;
        end
        if (wr_filt) st_d.filt = wdata & FILT_WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign filt_o = st_q.filt;
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int NUM_CTR    = 4,
    parameter int NUM_EVENTS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_EVENTS-1:0] ev_pulse,
    input  logic [1:0]            priv_lvl,
    input  logic                  dbg_inhibit,
    output logic                  export_en,
    output logic                  irq
);
    localparam logic [DATA_W-1:0] IMPL_MASK =
        (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_CTR) - DATA_W'(1));
    localparam logic [SEL_W-1:0] SEL_CYC = SEL_W'(CYC_BIT);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] cen;
        logic [DATA_W-1:0] ien;
        logic [DATA_W-1:0] ovf;
        logic [SEL_W-1:0]  sel;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                    zero_ev, zero_cyc, wr_filt, wr_cyc;
    logic [NUM_CTR-1:0]      wr_type_v, wr_cnt_v, wrap_ev;
    logic [DATA_W-1:0]       cnt_arr  [NUM_CTR];
    logic [DATA_W-1:0]       type_arr [NUM_CTR];
    logic [DATA_W-1:0]       cyc_cnt, cyc_filt, wrap_vec;
    logic                    wrap_cyc, cyc_active, sel_valid;
    logic [DATA_W-1:0]       sel_type, sel_cnt;
    logic [DATA_W-1:0]       en_mask, ovf_mask;
    logic [SEL_W-1:0]        sel_cur;

    // Write strobes decoded from the bus.
    always_comb begin
        zero_ev  = bus_wr && bus_addr == A_CTRL && bus_wdata[C_PRST];
        zero_cyc = bus_wr && bus_addr == A_CTRL && bus_wdata[C_CRST];
        wr_filt  = bus_wr && bus_addr == A_TYPE && st_q.sel == SEL_CYC;
        wr_cyc   = bus_wr && bus_addr == A_CYC;
        for (int k = 0; k < NUM_CTR; k++) begin
            wr_type_v[k] = bus_wr && bus_addr == A_TYPE && st_q.sel == SEL_W'(k);
            wr_cnt_v[k]  = bus_wr && bus_addr == A_DATA && st_q.sel == SEL_W'(k);
        end
    end

    generate
        for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
            perfmon_evcnt #(.NUM_EVENTS(NUM_EVENTS)) u_evcnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .active   (st_q.ctrl.run && st_q.cen[k]),
                .zero_all (zero_ev),
                .wr_type  (wr_type_v[k]),
                .wr_cnt   (wr_cnt_v[k]),
                .wdata    (bus_wdata),
                .ev_pulse (ev_pulse),
                .lvl      (priv_lvl),
                .cnt_o    (cnt_arr[k]),
                .type_o   (type_arr[k]),
                .wrap_o   (wrap_ev[k])
            );
        end
    endgenerate

    assign cyc_active = st_q.ctrl.run && st_q.cen[CYC_BIT]
                        && !(st_q.ctrl.dbg_stop && dbg_inhibit);

    perfmon_cyccnt u_cyccnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (cyc_active),
        .div64    (st_q.ctrl.div64),
        .zero_all (zero_cyc),
        .wr_cnt   (wr_cyc),
        .wr_filt  (wr_filt),
        .wdata    (bus_wdata),
        .lvl      (priv_lvl),
        .cnt_o    (cyc_cnt),
        .filt_o   (cyc_filt),
        .wrap_o   (wrap_cyc)
    );

    always_comb begin
        wrap_vec = '0;
        for (int k = 0; k < NUM_CTR; k++) wrap_vec[k] = wrap_ev[k];
        wrap_vec[CYC_BIT] = wrap_cyc;
    end

    // Next-state of the shared control and mask registers.
    always_comb begin
        logic [DATA_W-1:0] ovf_clr;
        st_d = st_q;
        if (bus_wr && bus_addr == A_CTRL) begin
            st_d.ctrl.run       = bus_wdata[C_EN];
            st_d.ctrl.div64     = bus_wdata[C_DIV];
            st_d.ctrl.export_on = bus_wdata[C_EXP];
            st_d.ctrl.dbg_stop  = bus_wdata[C_DBG];
        end
        if (bus_wr && bus_addr == A_ENSET) st_d.cen = st_q.cen | (bus_wdata & IMPL_MASK);
        if (bus_wr && bus_addr == A_ENCLR) st_d.cen = st_q.cen & ~bus_wdata;
        if (bus_wr && bus_addr == A_IESET) st_d.ien = st_q.ien | (bus_wdata & IMPL_MASK);
        if (bus_wr && bus_addr == A_IECLR) st_d.ien = st_q.ien & ~bus_wdata;
        if (bus_wr && bus_addr == A_SEL)   st_d.sel = bus_wdata[SEL_W-1:0];
        ovf_clr  = (bus_wr && bus_addr == A_OVF) ? bus_wdata : '0;
        // a wrap in the same cycle wins over the clearing write
        st_d.ovf = (st_q.ovf & ~ovf_clr) | wrap_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read path.
    always_comb begin
        sel_type  = '0;
        sel_cnt   = '0;
        sel_valid = 1'b0;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (st_q.sel == SEL_W'(k)) begin
                sel_valid = 1'b1;
                sel_type  = type_arr[k];
                sel_cnt   = cnt_arr[k];
            end
        end
        if (st_q.sel == SEL_CYC) sel_type = cyc_filt;

        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[C_NLO +: SEL_W] = SEL_W'(NUM_CTR);
                bus_rdata[C_EN]           = st_q.ctrl.run;
                bus_rdata[C_DIV]          = st_q.ctrl.div64;
                bus_rdata[C_EXP]          = st_q.ctrl.export_on;
                bus_rdata[C_DBG]          = st_q.ctrl.dbg_stop;
            end
            A_ENSET, A_ENCLR: bus_rdata = st_q.cen;
            A_IESET, A_IECLR: bus_rdata = st_q.ien;
            A_OVF:            bus_rdata = st_q.ovf;
            A_SEL:            bus_rdata[SEL_W-1:0] = st_q.sel;
            A_TYPE:           bus_rdata = sel_type;
            A_DATA:           bus_rdata = sel_valid ? sel_cnt : '0;
            A_CYC:            bus_rdata = cyc_cnt;
            default:          bus_rdata = '0;
        endcase
    end

    assign irq       = |(st_q.ovf & st_q.ien);
    assign export_en = st_q.ctrl.export_on;
    assign en_mask   = st_q.cen;
    assign ovf_mask  = st_q.ovf;
    assign sel_cur   = st_q.sel;
endmodule

// File: rtl/perfmon_chk.sv
module perfmon_chk
    import perfmon_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [SEL_W-1:0]  sel_cur,
    input logic [DATA_W-1:0] en_mask,
    input logic [DATA_W-1:0] ovf_mask,
    input logic [DATA_W-1:0] cyc_cnt
);
    // R8
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(ovf_mask) & ~ovf_mask)) |-> ($past(bus_wr) && $past(bus_addr) == A_OVF));

    // R3
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask != $past(en_mask)) |->
        ($past(bus_wr) && ($past(bus_addr) == A_ENSET || $past(bus_addr) == A_ENCLR)));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_mask != '0));

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |->
        (bus_rdata[C_NLO +: SEL_W] == SEL_W'(NUM_CTR) && bus_rdata[C_CRST:C_PRST] == 2'b00));

    // R7
    sel_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DATA && int'(sel_cur) >= NUM_CTR) |-> (bus_rdata == '0));

    // R10
    cyc_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt != $past(cyc_cnt)) |->
        (($past(bus_wr) && ($past(bus_addr) == A_CYC || $past(bus_addr) == A_CTRL))
         || $past(en_mask[CYC_BIT])));
endmodule

bind perfmon_unit perfmon_chk #(.NUM_CTR(NUM_CTR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .sel_cur   (sel_cur),
    .en_mask   (en_mask),
    .ovf_mask  (ovf_mask),
    .cyc_cnt   (cyc_cnt)
);

// File: tb/perfmon_unit_bench.sv
module perfmon_unit_bench;
    localparam int NC = 3;
    localparam int NE = 8;

    localparam logic [3:0] R_CTRL = 4'd0, R_ENS = 4'd1, R_ENC = 4'd2, R_IES = 4'd3,
                           R_IEC = 4'd4, R_OVF = 4'd5, R_SEL = 4'd6, R_TYP = 4'd7,
                           R_DAT = 4'd8, R_CYC = 4'd9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NE-1:0] ev_pulse = '0;
    logic [1:0]    priv_lvl = '0;
    logic          dbg_inhibit = 1'b0;
    logic          export_en;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    perfmon_unit #(.NUM_CTR(NC), .NUM_EVENTS(NE)) u_perfmon_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse),
        .priv_lvl(priv_lvl), .dbg_inhibit(dbg_inhibit), .export_en(export_en), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        @(negedge clk);
    endtask

    // Run bit high for exactly k counting edges.
    task automatic window(input logic [31:0] base, input int k);
        wr(R_CTRL, base | 32'h1);
        repeat (k - 1) @(negedge clk);
        wr(R_CTRL, base);
    endtask

    function automatic bit lvl_ok(input int f, input int lvl);
        case (lvl)
            0: return f[1] == 1'b0;
            1: return f[0] == 1'b0;
            2: return f[2] == 1'b1;
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_rd("R1 ctrl", R_CTRL, 32'h0000_1800);
        expect_rd("R1 enable", R_ENS, 32'h0);
        expect_rd("R1 int-enable", R_IES, 32'h0);
        expect_rd("R1 overflow", R_OVF, 32'h0);
        expect_rd("R1 select", R_SEL, 32'h0);
        expect_rd("R1 cycle", R_CYC, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 control register write mask
        wr(R_CTRL, 32'hFFFF_FFFF);
        expect_rd("R2 ctrl mask", R_CTRL, 32'h0000_1839);
        chk("R2 export", {31'b0, export_en}, 32'h1);
        wr(R_CTRL, 32'h0);

        // R3 set/clear masks
        wr(R_ENS, 32'hFFFF_FFFF);
        expect_rd("R3 enable set", R_ENS, 32'h8000_0007);
        wr(R_ENC, 32'h8000_0002);
        expect_rd("R3 enable clear", R_ENC, 32'h0000_0005);
        wr(R_IES, 32'h8000_0001);
        expect_rd("R3 ie set", R_IEC, 32'h8000_0001);
        wr(R_IEC, 32'hFFFF_FFFF);
        expect_rd("R3 ie clear", R_IES, 32'h0);
        wr(R_ENC, 32'hFFFF_FFFF);

        // R6 type write mask
        wr(R_SEL, 32'h0);
        wr(R_TYP, 32'hFFFF_FFFF);
        expect_rd("R6 type mask", R_TYP, 32'hC800_03FF);

        // R7 select and unimplemented selections
        for (int k = 0; k < NC; k++) begin
            wr(R_SEL, k);
            wr(R_DAT, 32'h100 + k);
        end
        wr(R_SEL, 32'hFFFF_FFE5);
        expect_rd("R7 select bits", R_SEL, 32'h5);
        wr(R_TYP, 32'h3);
        wr(R_DAT, 32'h1234);
        expect_rd("R7 hole type", R_TYP, 32'h0);
        expect_rd("R7 hole data", R_DAT, 32'h0);
        for (int k = 0; k < NC; k++) begin
            wr(R_SEL, k);
            expect_rd("R7 untouched", R_DAT, 32'h100 + k);
        end

        // R4/R6 sweep of event numbers across counters
        wr(R_ENS, 32'h7);
        for (int e = 0; e < 10; e++) begin
            int exp_c [NC];
            int evn [NC];
            for (int k = 0; k < NC; k++) begin
                evn[k] = (e + k) % 10;
                exp_c[k] = 0;
                wr(R_SEL, k);
                wr(R_TYP, evn[k]);
            end
            wr(R_CTRL, 32'h3);
            for (int j = 0; j < 20; j++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                ev_pulse = lfsr[NE-1:0];
                for (int k = 0; k < NC; k++)
                    if (evn[k] < NE && ev_pulse[evn[k]]) exp_c[k]++;
                @(negedge clk);
            end
            ev_pulse = '0;
            for (int k = 0; k < NC; k++) begin
                wr(R_SEL, k);
                expect_rd("R4 R6 event sweep", R_DAT, exp_c[k]);
            end
        end

        // R4 own enable and global run bit
        for (int k = 0; k < NC; k++) begin
            wr(R_SEL, k);
            wr(R_TYP, 32'h2);
        end
        wr(R_CTRL, 32'h3);
        wr(R_ENC, 32'h2);
        ev_pulse = '1;
        repeat (5) @(negedge clk);
        ev_pulse = '0;
        wr(R_CTRL, 32'h0);
        ev_pulse = '1;
        repeat (5) @(negedge clk);
        ev_pulse = '0;
        for (int k = 0; k < NC; k++) begin
            wr(R_SEL, k);
            expect_rd("R4 enable gating", R_DAT, (k == 1) ? 32'd0 : 32'd5);
        end
        wr(R_ENS, 32'h2);

        // R5 privilege filter sweep
        wr(R_SEL, 32'h0);
        for (int f = 0; f < 8; f++) begin
            for (int lvl = 0; lvl < 4; lvl++) begin
                logic [31:0] t;
                t = 32'h3;
                t[31] = f[0]; t[30] = f[1]; t[27] = f[2];
                wr(R_TYP, t);
                wr(R_CTRL, 32'h3);
                priv_lvl = 2'(lvl);
                ev_pulse = 8'h08;
                repeat (6) @(negedge clk);
                ev_pulse = '0;
                priv_lvl = 2'd0;
                expect_rd("R5 filter", R_DAT, lvl_ok(f, lvl) ? 32'd6 : 32'd0);
            end
        end

        // R6 clock event beyond the event-vector width
        wr(R_TYP, 32'h11);
        wr(R_CTRL, 32'h2);
        window(32'h0, 10);
        expect_rd("R6 clock event", R_DAT, 32'd10);

        // R8/R9 overflow flags and interrupt
        wr(R_ENC, 32'hFFFF_FFFF);
        wr(R_ENS, 32'h1);
        wr(R_CTRL, 32'h1);
        wr(R_TYP, 32'h3);
        wr(R_DAT, 32'hFFFF_FFFE);
        ev_pulse = 8'h08;
        repeat (2) @(negedge clk);
        ev_pulse = '0;
        expect_rd("R8 wrapped value", R_DAT, 32'h0);
        expect_rd("R8 flag set", R_OVF, 32'h1);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(R_IES, 32'h1);
        chk("R9 irq raised", {31'b0, irq}, 32'h1);
        wr(R_OVF, 32'h0);
        expect_rd("R8 zero write", R_OVF, 32'h1);
        wr(R_OVF, 32'h1);
        expect_rd("R8 w1c", R_OVF, 32'h0);
        chk("R9 irq dropped", {31'b0, irq}, 32'h0);
        wr(R_DAT, 32'hFFFF_FFFF);
        expect_rd("R8 sw write no flag", R_OVF, 32'h0);
        ev_pulse = 8'h08;
        wr(R_OVF, 32'h1);
        ev_pulse = '0;
        expect_rd("R8 set beats clear", R_OVF, 32'h1);
        chk("R9 irq on race", {31'b0, irq}, 32'h1);
        wr(R_OVF, 32'hFFFF_FFFF);
        wr(R_IEC, 32'hFFFF_FFFF);
        wr(R_CTRL, 32'h0);

        // R10 cycle counter
        wr(R_ENS, 32'h8000_0000);
        wr(R_SEL, 32'd31);
        wr(R_TYP, 32'h0);
        wr(R_CTRL, 32'h4);
        window(32'h0, 10);
        expect_rd("R10 cycle count", R_CYC, 32'd10);
        wr(R_CTRL, 32'h2);
        expect_rd("R2 event reset spares cycle", R_CYC, 32'd10);
        wr(R_CTRL, 32'h4);
        expect_rd("R2 cycle reset", R_CYC, 32'd0);
        expect_rd("R2 reset bits read zero", R_CTRL, 32'h0000_1800);
        window(32'h8, 130);
        expect_rd("R10 div64 130", R_CYC, 32'd2);
        wr(R_CTRL, 32'h4);
        window(32'h8, 127);
        expect_rd("R10 div64 127", R_CYC, 32'd1);
        wr(R_CTRL, 32'h4);

        // R5/R7 cycle filter through selection 31
        wr(R_TYP, 32'hFFFF_FFFF);
        expect_rd("R7 cycle filter mask", R_TYP, 32'hC800_0000);
        window(32'h0, 10);
        expect_rd("R5 cycle excluded", R_CYC, 32'd0);
        priv_lvl = 2'd3;
        window(32'h0, 10);
        priv_lvl = 2'd0;
        expect_rd("R5 cycle level3", R_CYC, 32'd10);
        wr(R_TYP, 32'h0);

        // R11 debug inhibit
        wr(R_CTRL, 32'h4);
        dbg_inhibit = 1'b1;
        window(32'h20, 10);
        expect_rd("R11 debug stop", R_CYC, 32'd0);
        window(32'h0, 5);
        expect_rd("R11 stop bit off", R_CYC, 32'd5);
        dbg_inhibit = 1'b0;
        window(32'h20, 10);
        expect_rd("R11 no inhibit", R_CYC, 32'd15);

        // R8/R9 cycle counter wrap on bit 31
        wr(R_CYC, 32'hFFFF_FFFF);
        window(32'h0, 1);
        expect_rd("R10 cycle wrap", R_CYC, 32'h0);
        expect_rd("R8 cycle flag", R_OVF, 32'h8000_0000);
        wr(R_IES, 32'h8000_0000);
        chk("R9 cycle irq", {31'b0, irq}, 32'h1);
        wr(R_OVF, 32'h8000_0000);
        chk("R9 cycle irq cleared", {31'b0, irq}, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule